// File: doc/BRIEF.md
# Five-Level Inverter Stage Sequencer

This block drives the eight gate enables of a single-source, five-level inverter cell. A caller asks for an output level measured in half-bus units (−2, −1, 0, +1, +2) and pulses an update strobe. The block holds the working stage that is currently applied and moves to a new stage on each strobe. The cell has three switch groups: a four-switch ladder, a two-switch selector between the ladder's two taps, and a two-switch selector on the return rail. Every stage turns on exactly one switch in each group.

The zero level and the two half levels can each be made by two different stages. The block picks the candidate that changes the fewest gate bits relative to the stage now applied, so it has to remember that stage. The full levels have only one stage each. The output may only move to a neighbouring level on any one strobe. If the request lies further away, the block takes one step toward it per strobe. The stage index is exposed so that a capacitor-balancing controller can tell which bus capacitor is being discharged.

The core is a state machine with eight states, ST1 to ST8, one for each working stage. On each strobe it takes one of three named transitions:
- **raise** moves one level up.
- **lower** moves one level down.
- **hold** keeps the same level. Because zero toggles always wins, hold keeps the same stage.

Without a strobe the state does not change.

Top module: `fl5_stage_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in stage ST3. After reset, `gate_o` = 8'b10001010, `stage_o` = 2 and `fault_o` = 0.
- R2: `gate_o` bit 7..0 is S1,S2,S3,S4,K1,K2,Q1,Q2, where 1 means the switch conducts. The stage codes are:
  - ST1 = 01001001 (+1)
  - ST2 = 00100101 (+1)
  - ST3 = 10001010 (0)
  - ST4 = 00010101 (0)
  - ST5 = 01001010 (−1)
  - ST6 = 00100110 (−1)
  - ST7 = 10001001 (+2)
  - ST8 = 00010110 (−2)
- R3: `lvl_req` codes are 0 = −2, 1 = −1, 2 = 0, 3 = +1 and 4 = +2. Codes 5 to 7 are treated as +2.
- R4: Each cycle with `upd` = 1 moves the applied level exactly one step toward the requested level (raise or lower). With `upd` = 0, `gate_o` and `stage_o` do not change, whatever the request.
- R5: A strobe whose request equals the applied level (hold) leaves the stage unchanged.
- R6: Among the candidate stages of the next level, the block applies the one whose code differs from the present `gate_o` in the fewest bits.
- R7: When two candidates need the same number of bit changes, the lower-numbered stage is applied. For example, ST1 going to level 0 gives ST3, and ST6 going to level 0 gives ST3.
- R8: `stage_o` is the stage number minus one (ST1 = 0 … ST8 = 7). It changes on the same clock edge as `gate_o`, one edge after the strobe is sampled.
- R9: `fault_o` is 1 exactly when `gate_o` does not have exactly one conducting switch in each group {S1..S4}, {K1,K2} and {Q1,Q2}. In legal operation it stays 0.
- R10: The applied output level never changes by more than one half-bus unit between consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd | input | 1 | Update strobe; one stage step per cycle it is high |
| lvl_req | input | 3 | Requested level code (R3) |
| gate_o | output | 8 | Registered gate enables, S1 in bit 7 |
| stage_o | output | 3 | Applied stage number minus one |
| fault_o | output | 1 | Group rule violation on `gate_o` |

## Verification
The hardest behaviour to reach from the ports is the tie-break. It only matters when the block leaves ST1 or ST6 toward level 0, so the stimulus has to walk there first. The bench climbs from reset to +2 and then walks down to −2, which passes through ST1 and on to level 0 on the way. It then steps back up from −2, which lands in ST6 and tests the second tie. Long jumps and out-of-range request codes are issued from known stages, so the one-step-per-strobe rule and the clamping to +2 show up as exact gate codes.

// File: rtl/fl5_pkg.sv
package fl5_pkg;

    localparam int GATE_W  = 8;
    localparam int LVL_W   = 3;
    localparam int MAX_LVL = 4;
    localparam int N_CAND  = 2;
    localparam int CNT_W   = $clog2(GATE_W + 1);

    typedef logic [GATE_W-1:0] gates_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    typedef enum logic [2:0] {
        ST1 = 3'd0,
        ST2 = 3'd1,
        ST3 = 3'd2,
        ST4 = 3'd3,
        ST5 = 3'd4,
        ST6 = 3'd5,
        ST7 = 3'd6,
        ST8 = 3'd7
    } stage_e;

    // bit 7..0 : S1 S2 S3 S4 K1 K2 Q1 Q2
    function automatic gates_t stage_gates(input stage_e s);
        gates_t g;
        unique case (s)
            ST1: g = 8'b0100_1001;
            ST2: g = 8'b0010_0101;
            ST3: g = 8'b1000_1010;
            ST4: g = 8'b0001_0101;
            ST5: g = 8'b0100_1010;
            ST6: g = 8'b0010_0110;
            ST7: g = 8'b1000_1001;
            ST8: g = 8'b0001_0110;
            default: g = 8'b1000_1010;
        endcase
        return g;
    endfunction

    // level code: 0=-2 .. 4=+2
    function automatic lvl_t stage_level(input stage_e s);
        lvl_t l;
        unique case (s)
            ST7:      l = 3'd4;
            ST1, ST2: l = 3'd3;
            ST3, ST4: l = 3'd2;
            ST5, ST6: l = 3'd1;
            ST8:      l = 3'd0;
            default:  l = 3'd2;
        endcase
        return l;
    endfunction

    // candidate k of a level; index 0 is always the lower-numbered stage
    function automatic stage_e level_cand(input lvl_t l, input int k);
        stage_e s;
        unique case (l)
            3'd0:    s = ST8;
            3'd1:    s = (k == 0) ? ST5 : ST6;
            3'd2:    s = (k == 0) ? ST3 : ST4;
            3'd3:    s = (k == 0) ? ST1 : ST2;
            3'd4:    s = ST7;
            default: s = ST7;
        endcase
        return s;
    endfunction

    function automatic logic [CNT_W-1:0] bit_toggles(input gates_t a, input gates_t b);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < GATE_W; i++) begin
            n = n + CNT_W'(a[i] ^ b[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/fl5_level_stepper.sv
module fl5_level_stepper
    import fl5_pkg::*;
#(
    parameter int MAX_CODE = MAX_LVL
) (
    input  lvl_t cur_lvl,
    input  lvl_t req_lvl,
    output lvl_t nxt_lvl
);

    localparam lvl_t TOP = lvl_t'(MAX_CODE);

    lvl_t req_c;

    always_comb begin
        req_c = (req_lvl > TOP) ? TOP : req_lvl;
        if (req_c > cur_lvl) begin
            nxt_lvl = cur_lvl + 3'd1;
        end else if (req_c < cur_lvl) begin
            nxt_lvl = cur_lvl - 3'd1;
        end else begin
            nxt_lvl = cur_lvl;
        end
    end

endmodule

// File: rtl/fl5_stage_picker.sv
module fl5_stage_picker
    import fl5_pkg::*;
#(
    parameter int NC = N_CAND
) (
    input  gates_t cur_gates,
    input  lvl_t   nxt_lvl,
    output stage_e pick
);

    stage_e           cand [NC];
    logic [CNT_W-1:0] cost [NC];

    for (genvar k = 0; k < NC; k++) begin : g_cand
        always_comb begin
            cand[k] = level_cand(nxt_lvl, k);
            cost[k] = bit_toggles(cur_gates, stage_gates(cand[k]));
        end
    end

    // strict less-than keeps the earlier (lower-numbered) candidate on a tie
    always_comb begin
        pick = cand[0];
        for (int k = 1; k < NC; k++) begin
            if (cost[k] < bit_toggles(cur_gates, stage_gates(pick))) begin
                pick = cand[k];
            end
        end
    end

endmodule

// File: rtl/fl5_group_monitor.sv
module fl5_group_monitor
    import fl5_pkg::*;
#(
    parameter int NGRP = 3
) (
    input  gates_t gates,
    output logic   fault
);

    localparam gates_t GMASK [3] = '{8'hF0, 8'h0C, 8'h03};

    logic [NGRP-1:0] bad;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign bad[g] = ($countones(gates & GMASK[g]) != 1);
    end

    assign fault = |bad;

endmodule

// File: rtl/fl5_stage_seq.sv
module fl5_stage_seq
    import fl5_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        upd,
    input  logic [2:0]  lvl_req,
    output logic [7:0]  gate_o,
    output logic [2:0]  stage_o,
    output logic        fault_o
);

    localparam stage_e RST_STAGE = ST3;

    stage_e state_q, state_d, pick;
    lvl_t   cur_lvl, nxt_lvl;
    gates_t gate_q;

    always_comb cur_lvl = stage_level(state_q);

    fl5_level_stepper #(.MAX_CODE(MAX_LVL)) u_step (
        .cur_lvl (cur_lvl),
        .req_lvl (lvl_req),
        .nxt_lvl (nxt_lvl)
    );

    fl5_stage_picker #(.NC(N_CAND)) u_pick (
        .cur_gates (gate_q),
        .nxt_lvl   (nxt_lvl),
        .pick      (pick)
    );

    // next state: raise / lower / hold on a strobe, otherwise stay
    always_comb begin
        state_d = state_q;
        if (upd) begin
            unique case (state_q)
                ST1, ST2, ST3, ST4, ST5, ST6, ST7, ST8: state_d = pick;
                default:                                state_d = RST_STAGE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RST_STAGE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register: gates follow the state entered on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= stage_gates(RST_STAGE);
        end else begin
            gate_q <= stage_gates(state_d);
        end
    end

    fl5_group_monitor #(.NGRP(3)) u_mon (
        .gates (gate_q),
        .fault (fault_o)
    );

    assign gate_o  = gate_q;
    assign stage_o = 3'(state_q);

endmodule

// File: rtl/fl5_stage_seq_chk.sv
module fl5_stage_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       upd,
    input logic [2:0] lvl_req,
    input logic [7:0] gate_o,
    input logic [2:0] stage_o,
    input logic       fault_o
);

    // output in half-bus units from the switch positions alone
    function automatic int vout(input logic [7:0] g);
        int c, d;
        c = g[3] ? (g[7] ? 2 : 1) : (g[5] ? 1 : 0);
        d = g[1] ? 2 : 0;
        return c - d;
    endfunction

    function automatic int tgt(input logic [2:0] r);
        return ((r > 3'd4) ? 4 : int'(r)) - 2;
    endfunction

    p_reset_stage_r1: assert property (@(posedge clk)
        rst |=> (gate_o == 8'b1000_1010 && stage_o == 3'd2 && !fault_o));

    p_group_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        ($countones(gate_o[7:4]) == 1 && $countones(gate_o[3:2]) == 1 &&
         $countones(gate_o[1:0]) == 1 && !fault_o));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(gate_o) && $stable(stage_o)));

    p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
        (upd && tgt(lvl_req) > vout(gate_o)) |=> (vout(gate_o) == vout($past(gate_o)) + 1));

    p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
        (upd && tgt(lvl_req) < vout(gate_o)) |=> (vout(gate_o) == vout($past(gate_o)) - 1));

    p_same_level_r5: assert property (@(posedge clk) disable iff (rst)
        (upd && tgt(lvl_req) == vout(gate_o)) |=> $stable(gate_o));

    p_adjacent_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((vout(gate_o) - vout($past(gate_o)) <= 1) &&
                  (vout($past(gate_o)) - vout(gate_o) <= 1)));

endmodule

bind fl5_stage_seq fl5_stage_seq_chk u_chk (.*);

// File: tb/fl5_stage_seq_tb.sv
module fl5_stage_seq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd = 1'b0;
    logic [2:0] lvl_req = 3'd2;
    logic [7:0] gate_o;
    logic [2:0] stage_o;
    logic       fault_o;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [7:0] G1 = 8'b0100_1001, G3 = 8'b1000_1010, G5 = 8'b0100_1010,
                           G6 = 8'b0010_0110, G7 = 8'b1000_1001, G8 = 8'b0001_0110;

    always #5 clk = ~clk;

    fl5_stage_seq u_dut (
        .clk (clk), .rst (rst), .upd (upd), .lvl_req (lvl_req),
        .gate_o (gate_o), .stage_o (stage_o), .fault_o (fault_o)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // check gates, index and fault together
    task automatic chk_stage(input string tag, input logic [7:0] eg, input logic [2:0] ei);
        chk({tag, " gates"}, gate_o, eg);
        chk({tag, " stage_o R8"}, {5'd0, stage_o}, {5'd0, ei});
        chk({tag, " fault R9"}, {7'd0, fault_o}, 8'd0);
    endtask

    task automatic strobe(input logic [2:0] l);
        @(negedge clk);
        lvl_req = l;
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk_stage("R1 reset", G3, 3'd2);
    endtask

    task automatic t_ramp_up;
        strobe(3'd3); chk_stage("R6 ST3->+1 picks ST1", G1, 3'd0);
        strobe(3'd4); chk_stage("R4 raise to ST7", G7, 3'd6);
        strobe(3'd4); chk_stage("R5 hold at ST7", G7, 3'd6);
    endtask

    task automatic t_idle;
        @(negedge clk);
        lvl_req = 3'd0;
        repeat (4) @(negedge clk);
        chk_stage("R4 no strobe no change", G7, 3'd6);
    endtask

    task automatic t_walk_down;
        strobe(3'd0); chk_stage("R10 one step from +2 to ST1", G1, 3'd0);
        strobe(3'd0); chk_stage("R7 tie ST1->0 gives ST3", G3, 3'd2);
        strobe(3'd0); chk_stage("R6 ST3->-1 picks ST5", G5, 3'd4);
        strobe(3'd0); chk_stage("R2 ST8 code", G8, 3'd7);
        strobe(3'd0); chk_stage("R5 hold at ST8", G8, 3'd7);
    endtask

    task automatic t_walk_up;
        strobe(3'd1); chk_stage("R6 ST8->-1 picks ST6", G6, 3'd5);
        strobe(3'd2); chk_stage("R7 tie ST6->0 gives ST3", G3, 3'd2);
    endtask

    task automatic t_clamp;
        strobe(3'd7); chk_stage("R3 code7 steps to ST1", G1, 3'd0);
        strobe(3'd5); chk_stage("R3 code5 reaches ST7", G7, 3'd6);
        strobe(3'd6); chk_stage("R3 code6 holds ST7", G7, 3'd6);
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_stage("R1 reset mid-run", G3, 3'd2);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_ramp_up();
                t_idle();
                t_walk_down();
                t_walk_up();
                t_clamp();
                t_reset_mid();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule